// File: doc/BRIEF.md
# Complement-Mode Adder-Subtractor

This combinational unit adds or subtracts two `WIDTH`-bit operands. It uses one ripple chain of full-adder cells. To subtract, the unit adds the complement of the second operand. A mode select picks the arithmetic:

- **Two's-complement mode.** The carry out of the top cell is dropped, and subtraction seeds the chain with a carry of one.
- **One's-complement mode.** The carry out of the top cell wraps back into the least significant position as an end-around carry.

The unit has no clock and no reset. Every output follows the inputs through logic only.

Besides the raw sum and the carry, the unit gives a sign-and-magnitude view of unsigned subtraction. If no end carry appears, the minuend was smaller, so the negative flag rises and the sum is recomplemented into a magnitude. A signed overflow flag covers both modes. The mode, the operation and the width are the only settings.

Top module: `compl_addsub`

## Requirements
- R1: With `onesMode`=0 and `subtract`=0, `{carryOut,sumOut}` equals `a + b` as a `WIDTH+1`-bit unsigned value.
- R2: With `onesMode`=0 and `subtract`=1, `sumOut` equals `a - b` modulo 2^WIDTH. `carryOut` is 1 exactly when `a >= b` as unsigned values.
- R3: With `onesMode`=0 and `subtract`=1, `negOut` is 1 exactly when `a < b` unsigned. `magOut` equals `|a - b|`.
- R4: With `subtract`=0 in either mode, `negOut` is 0 and `magOut` equals `sumOut`.
- R5: With `onesMode`=1 and `subtract`=0, let `t` = `a + b`. `carryOut` is bit WIDTH of `t`, and `sumOut` is the low WIDTH bits of `t` plus that carry, modulo 2^WIDTH.
- R6: With `onesMode`=1 and `subtract`=1, the unit adds the bitwise NOT of `b` and applies the end-around carry.
  - If `a >= b` is not the case for equal operands, the rule is: when `a > b`, `carryOut`=1, `sumOut` = `a - b` and `negOut`=0.
  - When `a < b`, `negOut`=1 and `magOut` = `b - a`, which is the bitwise NOT of `sumOut`.
  - When `a == b`, `sumOut` is all ones, `carryOut`=0, `negOut`=1 and `magOut`=0.
- R7: With `onesMode`=0, `ovfOut` is 1 exactly when the true signed two's-complement result lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1]. This equals the carry into the top cell XOR the carry out of it.
- R8: With `onesMode`=1, the operands are read as signed one's-complement values, where bit WIDTH-1 set means the value is minus the bitwise NOT. `ovfOut` is 1 exactly when the true result lies outside [-(2^(WIDTH-1)-1), 2^(WIDTH-1)-1].
- R9: At WIDTH=7 in two's-complement subtraction:
  - 1010100 minus 1000011 gives `magOut`=0010001 and `negOut`=0.
  - The swapped operands give the same magnitude with `negOut`=1.
- R10: At WIDTH=8 in two's-complement addition, 70 + 80 asserts `ovfOut`, and so does -70 + -80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand (minuend when subtracting) |
| b | input | WIDTH | Second operand (subtrahend when subtracting) |
| subtract | input | 1 | 1 selects a minus b, 0 selects a plus b |
| onesMode | input | 1 | 1 selects one's-complement arithmetic with end-around carry, 0 selects two's complement |
| sumOut | output | WIDTH | Sum bits after any end-around carry |
| carryOut | output | 1 | Carry out of the top cell of the ripple chain |
| magOut | output | WIDTH | Magnitude of an unsigned difference, or the sum when adding |
| negOut | output | 1 | Unsigned subtraction result is negative |
| ovfOut | output | 1 | Signed overflow for the selected complement mode |

## Verification
The unit holds no state, so a wrong internal value shows at the outputs in the same evaluation as the inputs that expose it. There is no latency to wait out.

The possible faults each leave a distinct trace:
- A broken carry link in the ripple chain corrupts `sumOut` only for operand pairs whose carries cross that cell.
- A wrong end-around or recomplement strobe shows only in one mode and operation.
- A bad overflow rule shows only near the signed range limits.

For these reasons, every mode and operation is swept over all 8-bit operand pairs, and the results are compared with values computed arithmetically.

// File: rtl/compl_addsub_pkg.sv
package compl_addsub_pkg;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic invertB;      // complement the second operand
    logic carrySeed;    // initial carry into bit 0
    logic wrapCarry;    // feed the top carry back into bit 0
    logic signFix;      // unsigned sign-and-magnitude correction enabled
    logic fixAddOne;    // correction adds one after the bitwise NOT
    logic carryRuleOvf; // overflow from carry pair instead of sign rule
  } addsubStrobes_t;

endpackage

// File: rtl/compl_addsub_cell.sv
module compl_addsub_cell (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic propagate;
  logic generateBit;

  assign propagate   = x ^ y;
  assign generateBit = x & y;
  assign s           = propagate ^ cin;
  assign cout        = generateBit | (cin & propagate);
endmodule

// File: rtl/compl_addsub_inc.sv
module compl_addsub_inc #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] val,
  input  logic             inc,
  output logic [WIDTH-1:0] res
);
  logic [WIDTH-1:0] chain;

  assign chain[0] = inc;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign res[i] = val[i] ^ chain[i];
    if (i < WIDTH - 1) begin : g_link
      assign chain[i+1] = val[i] & chain[i];
    end
  end
endmodule

// File: rtl/compl_addsub_ctrl.sv
module compl_addsub_ctrl
  import compl_addsub_pkg::*;
(
  input  logic           subtract,
  input  logic           onesMode,
  output addsubStrobes_t strobes
);
  always_comb begin
    strobes.invertB      = subtract;
    strobes.carrySeed    = subtract & ~onesMode;
    strobes.wrapCarry    = onesMode;
    strobes.signFix      = subtract;
    strobes.fixAddOne    = ~onesMode;
    strobes.carryRuleOvf = ~onesMode;
  end
endmodule

// File: rtl/compl_addsub_dp.sv
module compl_addsub_dp
  import compl_addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  addsubStrobes_t   strobes,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic [WIDTH-1:0] magOut,
  output logic             negOut,
  output logic             ovfOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] firstPass;
  logic [WIDTH-1:0] wrapped;
  logic [WIDTH-1:0] wrappedInv;
  logic [WIDTH-1:0] recomp;
  logic [WIDTH:0]   carry;
  logic             wrapInc;
  logic             signRuleOvf;
  logic             carryRuleOvf;

  assign bEff     = b ^ {WIDTH{strobes.invertB}};
  assign carry[0] = strobes.carrySeed;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    compl_addsub_cell uCell (
      .x   (a[i]),
      .y   (bEff[i]),
      .cin (carry[i]),
      .s   (firstPass[i]),
      .cout(carry[i+1])
    );
  end

  // End-around carry pass (one's-complement mode only).
  assign wrapInc = strobes.wrapCarry & carry[WIDTH];

  compl_addsub_inc #(.WIDTH(WIDTH)) uWrap (
    .val(firstPass),
    .inc(wrapInc),
    .res(wrapped)
  );

  // Recomplement path for a negative unsigned difference.
  assign wrappedInv = ~wrapped;

  compl_addsub_inc #(.WIDTH(WIDTH)) uFix (
    .val(wrappedInv),
    .inc(strobes.fixAddOne),
    .res(recomp)
  );

  assign carryRuleOvf = carry[WIDTH] ^ carry[MSB];
  assign signRuleOvf  = (a[MSB] == bEff[MSB]) & (wrapped[MSB] != a[MSB]);

  always_comb begin
    sumOut   = wrapped;
    carryOut = carry[WIDTH];
    negOut   = strobes.signFix & ~carry[WIDTH];
    magOut   = negOut ? recomp : wrapped;
    ovfOut   = strobes.carryRuleOvf ? carryRuleOvf : signRuleOvf;
  end
endmodule

// File: rtl/compl_addsub.sv
module compl_addsub
  import compl_addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             subtract,
  input  logic             onesMode,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut,
  output logic [WIDTH-1:0] magOut,
  output logic             negOut,
  output logic             ovfOut
);
  addsubStrobes_t strobes;

  compl_addsub_ctrl uCtrl (
    .subtract(subtract),
    .onesMode(onesMode),
    .strobes (strobes)
  );

  compl_addsub_dp #(.WIDTH(WIDTH)) uDp (
    .a       (a),
    .b       (b),
    .strobes (strobes),
    .sumOut  (sumOut),
    .carryOut(carryOut),
    .magOut  (magOut),
    .negOut  (negOut),
    .ovfOut  (ovfOut)
  );
endmodule

// File: rtl/compl_addsub_chk.sv
module compl_addsub_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             subtract,
  input logic             onesMode,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut,
  input logic [WIDTH-1:0] magOut,
  input logic             negOut,
  input logic             ovfOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opB;
  logic [WIDTH:0]   twosFull;

  assign opB      = subtract ? ~b : b;
  assign twosFull = {1'b0, a} + {1'b0, opB} + {{WIDTH{1'b0}}, subtract};

  always_comb begin
    if (!onesMode) begin
      assert_twos_result_R2: assert ({carryOut, sumOut} == twosFull);
      assert_ovf_signrule_R7: assert (ovfOut ==
        ((a[MSB] == opB[MSB]) && (sumOut[MSB] != a[MSB])));
    end
    if (!subtract) begin
      assert_add_nofix_R4: assert (!negOut && (magOut == sumOut));
    end
    if (subtract) begin
      assert_neg_carry_R3: assert (negOut == !carryOut);
    end
    if (subtract && !onesMode && negOut) begin
      assert_mag_twos_R3: assert (magOut == WIDTH'(b - a));
    end
    if (subtract && onesMode && negOut) begin
      assert_mag_ones_R6: assert (magOut == ~sumOut);
    end
  end
endmodule

bind compl_addsub compl_addsub_chk #(.WIDTH(WIDTH)) uChk (
  .a       (a),
  .b       (b),
  .subtract(subtract),
  .onesMode(onesMode),
  .sumOut  (sumOut),
  .carryOut(carryOut),
  .magOut  (magOut),
  .negOut  (negOut),
  .ovfOut  (ovfOut)
);

// File: tb/tb_compl_addsub.sv
module tb_compl_addsub;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] a, b, sumOut, magOut;
  logic subtract, onesMode, carryOut, negOut, ovfOut;

  logic [6:0] a7, b7, sum7, mag7;
  logic carry7, neg7, ovf7;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  compl_addsub #(.WIDTH(8)) dut (
    .a(a), .b(b), .subtract(subtract), .onesMode(onesMode),
    .sumOut(sumOut), .carryOut(carryOut), .magOut(magOut),
    .negOut(negOut), .ovfOut(ovfOut)
  );

  compl_addsub #(.WIDTH(7)) dutSeven (
    .a(a7), .b(b7), .subtract(1'b1), .onesMode(1'b0),
    .sumOut(sum7), .carryOut(carry7), .magOut(mag7),
    .negOut(neg7), .ovfOut(ovf7)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s a=%0d b=%0d sub=%0d ones=%0d actual=%0d expected=%0d",
               req, what, a, b, subtract, onesMode, act, exp);
    end
  endtask

  function automatic int onesVal(input logic [7:0] x);
    return x[7] ? -int'(8'(~x)) : int'(x);
  endfunction

  function automatic int twosVal(input logic [7:0] x);
    return x[7] ? int'(x) - 256 : int'(x);
  endfunction

  initial begin
    int expSum, expCarry, expNeg, expMag, expOvf, res, t;
    logic [7:0] bb;
    string rs, rn, ro;

    a = 0; b = 0; subtract = 0; onesMode = 0;
    a7 = 0; b7 = 0;
    #3;
    // Idle state with all-zero inputs
    check("R1", "idle sum", int'(sumOut), 0);
    check("R4", "idle neg", int'(negOut), 0);
    check("R7", "idle ovf", int'(ovfOut), 0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int ia = 0; ia < 256; ia++) begin
          for (int ib = 0; ib < 256; ib++) begin
            a = 8'(ia); b = 8'(ib); subtract = s[0]; onesMode = m[0];
            #1;
            bb = s[0] ? ~b : b;
            if (m == 0) begin
              t        = ia + int'(bb) + s;
              expCarry = t / 256;
              expSum   = t % 256;
              expNeg   = s & (1 - expCarry);
              expMag   = expNeg ? (256 - expSum) % 256 : expSum;
              res      = s ? twosVal(a) - twosVal(b) : twosVal(a) + twosVal(b);
              expOvf   = (res > 127 || res < -128) ? 1 : 0;
              rs = s ? "R2" : "R1";
              rn = s ? "R3" : "R4";
              ro = "R7";
            end else begin
              t        = ia + int'(bb);
              expCarry = t / 256;
              expSum   = (t % 256 + expCarry) % 256;
              expNeg   = s & (1 - expCarry);
              expMag   = expNeg ? 255 - expSum : expSum;
              res      = onesVal(a) + onesVal(bb);
              expOvf   = (res > 127 || res < -127) ? 1 : 0;
              rs = s ? "R6" : "R5";
              rn = s ? "R6" : "R4";
              ro = "R8";
            end
            check(rs, "sum", int'(sumOut), expSum);
            check(rs, "carry", int'(carryOut), expCarry);
            check(rn, "neg", int'(negOut), expNeg);
            check(rn, "mag", int'(magOut), expMag);
            check(ro, "ovf", int'(ovfOut), expOvf);
          end
        end
      end
    end

    // R6 equal operands in one's-complement subtraction: negative zero
    a = 8'd37; b = 8'd37; subtract = 1; onesMode = 1; #1;
    check("R6", "eq sum", int'(sumOut), 255);
    check("R6", "eq carry", int'(carryOut), 0);
    check("R6", "eq neg", int'(negOut), 1);
    check("R6", "eq mag", int'(magOut), 0);

    // R9 seven-bit unsigned subtraction and its swap
    a7 = 7'b1010100; b7 = 7'b1000011; #1;
    check("R9", "mag7", int'(mag7), 17);
    check("R9", "neg7", int'(neg7), 0);
    a7 = 7'b1000011; b7 = 7'b1010100; #1;
    check("R9", "mag7 swap", int'(mag7), 17);
    check("R9", "neg7 swap", int'(neg7), 1);

    // R10 signed overflow on same-sign addition
    a = 8'd70; b = 8'd80; subtract = 0; onesMode = 0; #1;
    check("R10", "70+80 ovf", int'(ovfOut), 1);
    a = 8'(-70); b = 8'(-80); #1;
    check("R10", "-70+-80 ovf", int'(ovfOut), 1);

    done = 1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule